// File: doc/BRIEF.md
# Ethernet PHY Quick-Status Word with Configurable Interrupt

This block condenses the live condition of a 10/100 Ethernet PHY into one management-readable word. It shows descrambler lock loss or jabber, a latched link-good indication, and the partner pause, speed and duplex values. It also keeps three sticky event flags and a dual-purpose flag at bit 14. Event bits stay set until they are read. The link-good bit stays low after a failure until it is read. Reading the word clears what was reported.

A management engine pulses `rdStb` for one cycle to read the word and `wrStb` with `wrData` to write the two control bits. One of the two control bits chooses whether bit 14 shows receive errors or link-status changes. That bit also chooses which events drive the interrupt. The other control bit silences the interrupt entirely. The interrupt is a level held high by the flags that caused it, so it drops once a read has cleared those flags.

Top module: `qsStatusReg`

## Requirements
- R1: While `rstN` is low and right after reset, `rdData` is 0, `irq` is 0, and both control bits read 0.
- R2: A snapshot carries the partner-pause input at bit 10, the speed input at bit 9 (1 = 100 Mb/s) and the duplex input at bit 8 (1 = full), as sampled in the read cycle. Bits 5..0 and every bit above 15 read 0.
- R3: Bit 12 is a sticky flag. While the speed input is 1 it is set by `lockLossStb`, and while the speed input is 0 it is set by `jabberStb`. The strobe that does not match the current speed has no effect. Once set, the flag holds until a read reports it.
- R4: Bits 15 (`faultStb`) and 13 (`pageRxStb`) are sticky flags. They set in the cycle after their strobe. A read that reports a flag as 1 clears it in the cycle after the read. A strobe that arrives in the read cycle itself, or in the clearing cycle, is kept and shows on the next read.
- R5: Bit 11 reads 1 only while the link is up and has not dropped since the last read that showed 0. Any cycle with `linkRaw` low forces it to 0. It stays 0 through link recovery until a read reports the 0. After that read it follows `linkRaw` again.
- R6: When control bit 7 is 0, bit 14 is a sticky receive-error flag set by `rxErrStb`. When control bit 7 is 1, bit 14 is a sticky flag set by any change of `linkRaw`. Both flags clear on read, as in R4.
- R7: When bit 7 is 0 and bit 6 is 0, `irq` is 1 while any of these is pending: sticky bits 15, 13 or 12, the receive-error flag, or a fall of `linkRaw` not yet reported by a read that showed bit 11 as 0.
- R8: When bit 7 is 1 and bit 6 is 0, `irq` equals the link-change flag. Receive errors and the other sticky events do not raise it.
- R9: When bit 6 is 1, `irq` is 0 whatever is pending. Clearing bit 6 lets still-pending causes raise `irq` again.
- R10: A write loads only `wrData[7]` into bit 7 and `wrData[6]` into bit 6. Every other data bit is ignored. Both control bits read back at the same positions.
- R11: `rdData` changes only in the cycle after `rdStb`. It then holds the word as it stood in the read cycle, and keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| faultStb | input | 1 | Event strobe for sticky bit 15 |
| rxErrStb | input | 1 | Receive-error strobe (bit 14 when bit 7 = 0) |
| pageRxStb | input | 1 | Event strobe for sticky bit 13 |
| lockLossStb | input | 1 | Descrambler lock loss, counted at 100 Mb/s |
| jabberStb | input | 1 | Jabber detect, counted at 10 Mb/s |
| linkRaw | input | 1 | Live link-good level from the datapath |
| partnerPause | input | 1 | Link partner requests flow control |
| speed100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| fullDuplex | input | 1 | 1 = full duplex, 0 = half duplex |
| rdStb | input | 1 | Management read, one cycle |
| wrStb | input | 1 | Management write, one cycle |
| wrData | input | REG_W | Write data; only bits 7 and 6 are used |
| rdData | output | REG_W | Snapshot of the status word |
| irq | output | 1 | Interrupt level |

## Verification
The bench builds the block with its default `REG_W` of 16. At that width every status position is visible, and no upper padding bits are left unchecked.

Directed sequences cover these cases:
- a read that coincides with an event
- a one-cycle link drop with recovery before the read
- switching the bit-14 meaning while flags are pending
- masking and then unmasking a pending cause
- the speed-dependent choice of source for bit 12

A long sparse-random phase follows. It drives back-to-back reads, writes with junk bits, and strobes that land in the clearing cycle.

// File: rtl/qsPkg.sv
package qsPkg;
  localparam int QS_MIN_W    = 16;
  localparam int POS_FAULT   = 15;
  localparam int POS_DUAL    = 14;
  localparam int POS_PAGE    = 13;
  localparam int POS_LOCKJAB = 12;
  localparam int POS_LINK    = 11;
  localparam int POS_PAUSE   = 10;
  localparam int POS_SPEED   = 9;
  localparam int POS_DUPLEX  = 8;
  localparam int POS_CFG     = 7;
  localparam int POS_MASK    = 6;
  localparam int STICKY_N    = 3;

  // plain sticky flags: index 0 fault, 1 page, 2 lock/jabber
  function automatic int stickyPos(input int idx);
    case (idx)
      0:       return POS_FAULT;
      1:       return POS_PAGE;
      default: return POS_LOCKJAB;
    endcase
  endfunction

  typedef struct packed {
    logic capture;   // take a snapshot this cycle
    logic clear;     // apply clear-on-read of last snapshot
    logic cfgLoad;   // control bits are being written
  } qsStb_t;
endpackage

// File: rtl/qsCtrl.sv
module qsCtrl
  import qsPkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic [REG_W-1:0] wrData,
  output qsStb_t           stb,
  output logic             cfgQ,
  output logic             maskQ
);
  logic clearQ;
  logic unusedWrBits;

  assign unusedWrBits = ^{wrData[REG_W-1:POS_CFG+1], wrData[POS_MASK-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clearQ <= 1'b0;
      cfgQ   <= 1'b0;
      maskQ  <= 1'b0;
    end else begin
      clearQ <= rdStb;
      if (wrStb) begin
        cfgQ  <= wrData[POS_CFG];
        maskQ <= wrData[POS_MASK];
      end
    end
  end

  always_comb begin
    stb.capture = rdStb;
    stb.clear   = clearQ;
    stb.cfgLoad = wrStb;
  end

  // R10: without a write the control bits keep their value
  p_ctl_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrStb |=> ($stable(cfgQ) && $stable(maskQ)));

  // R11: a clear phase only ever follows a read
  p_clear_after_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> !stb.clear);
endmodule

// File: rtl/qsDatapath.sv
module qsDatapath
  import qsPkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  qsStb_t           stb,
  input  logic             cfgQ,
  input  logic             maskQ,
  input  logic             faultStb,
  input  logic             rxErrStb,
  input  logic             pageRxStb,
  input  logic             lockLossStb,
  input  logic             jabberStb,
  input  logic             linkRaw,
  input  logic             partnerPause,
  input  logic             speed100,
  input  logic             fullDuplex,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);
  logic [STICKY_N-1:0] stickyQ, stickyVis, stickyEvt;
  logic rxErrQ, chgQ, fellQ, linkOkQ, linkPrevQ;
  logic rxVis, chgVis, fellVis, linkVis, reload, snapCfg, unusedCfgLoad;
  logic [REG_W-1:0] word, snapQ;

  assign unusedCfgLoad = stb.cfgLoad;
  assign snapCfg = snapQ[POS_CFG];
  assign reload  = stb.clear & ~snapQ[POS_LINK];

  assign stickyEvt[0] = faultStb;
  assign stickyEvt[1] = pageRxStb;
  assign stickyEvt[2] = speed100 ? lockLossStb : jabberStb;

  for (genvar g = 0; g < STICKY_N; g++) begin : gSticky
    localparam int P = stickyPos(g);
    assign stickyVis[g] = stickyQ[g] & ~(stb.clear & snapQ[P]);
  end

  always_comb begin
    if (stb.clear) begin
      rxVis  = snapCfg ? 1'b0 : (rxErrQ & ~snapQ[POS_DUAL]);
      chgVis = snapCfg ? (chgQ & ~snapQ[POS_DUAL]) : 1'b0;
    end else begin
      rxVis  = rxErrQ;
      chgVis = chgQ;
    end
    linkVis = reload ? linkRaw : linkOkQ;
    fellVis = reload ? 1'b0 : fellQ;
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < STICKY_N; i++) word[stickyPos(i)] = stickyVis[i];
    word[POS_DUAL]   = cfgQ ? chgVis : rxVis;
    word[POS_LINK]   = linkVis;
    word[POS_PAUSE]  = partnerPause;
    word[POS_SPEED]  = speed100;
    word[POS_DUPLEX] = fullDuplex;
    word[POS_CFG]    = cfgQ;
    word[POS_MASK]   = maskQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyQ   <= '0;
      rxErrQ    <= 1'b0;
      chgQ      <= 1'b0;
      fellQ     <= 1'b0;
      linkOkQ   <= 1'b0;
      linkPrevQ <= 1'b0;
      snapQ     <= '0;
    end else begin
      stickyQ   <= stickyVis | stickyEvt;
      rxErrQ    <= rxVis | rxErrStb;
      chgQ      <= chgVis | (linkPrevQ ^ linkRaw);
      fellQ     <= fellVis | (linkPrevQ & ~linkRaw);
      linkOkQ   <= linkVis & linkRaw;
      linkPrevQ <= linkRaw;
      if (stb.capture) snapQ <= word;
    end
  end

  assign rdData = snapQ;
  assign irq = ~maskQ & (cfgQ ? chgQ : (|stickyQ | rxErrQ | fellQ));

  // R4: a fault strobe is always visible as pending in the next cycle
  p_fault_sticks_r4: assert property (@(posedge clk) disable iff (!rstN)
    faultStb |=> stickyQ[0]);

  // R5: a low link level forces the latched link bit low
  p_latch_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !linkRaw |=> !linkOkQ);

  // R9: the mask silences the pin
  p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    maskQ |-> !irq);

  // R8: in link-change mode the pin is only driven by the change flag
  p_cfg_only_change_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ && irq) |-> chgQ);

  // R11: the read word holds between reads
  p_snap_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(rdData));
endmodule

// File: rtl/qsStatusReg.sv
module qsStatusReg
  import qsPkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             faultStb,
  input  logic             rxErrStb,
  input  logic             pageRxStb,
  input  logic             lockLossStb,
  input  logic             jabberStb,
  input  logic             linkRaw,
  input  logic             partnerPause,
  input  logic             speed100,
  input  logic             fullDuplex,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);
  qsStb_t stb;
  logic   cfgQ, maskQ;

  qsCtrl #(.REG_W(REG_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .rdStb  (rdStb),
    .wrStb  (wrStb),
    .wrData (wrData),
    .stb    (stb),
    .cfgQ   (cfgQ),
    .maskQ  (maskQ)
  );

  qsDatapath #(.REG_W(REG_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cfgQ         (cfgQ),
    .maskQ        (maskQ),
    .faultStb     (faultStb),
    .rxErrStb     (rxErrStb),
    .pageRxStb    (pageRxStb),
    .lockLossStb  (lockLossStb),
    .jabberStb    (jabberStb),
    .linkRaw      (linkRaw),
    .partnerPause (partnerPause),
    .speed100     (speed100),
    .fullDuplex   (fullDuplex),
    .rdData       (rdData),
    .irq          (irq)
  );
endmodule

// File: tb/tb_qsStatusReg.sv
module tb_qsStatusReg;
  localparam int REG_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic faultStb = 0, rxErrStb = 0, pageRxStb = 0, lockLossStb = 0, jabberStb = 0;
  logic linkRaw = 0, partnerPause = 0, speed100 = 0, fullDuplex = 0;
  logic rdStb = 0, wrStb = 0;
  logic [REG_W-1:0] wrData = '0;
  logic [REG_W-1:0] rdData;
  logic irq;

  always #5 clk = ~clk;

  qsStatusReg #(.REG_W(REG_W)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model, updated on each rising edge
  bit mCfg, mMask, mF, mRx, mChg, mP, mLJ, mFell, mLink, mPrev, mClr;
  logic [15:0] mSnap;
  bit vF, vP, vLJ, vRx, vChg, vLink, vFell, rl;
  logic [15:0] w;

  always @(posedge clk) begin
    if (!rstN) begin
      {mCfg, mMask, mF, mRx, mChg, mP, mLJ, mFell, mLink, mPrev, mClr} = '0;
      mSnap = '0;
    end else begin
      vF  = mF  && !(mClr && mSnap[15]);
      vP  = mP  && !(mClr && mSnap[13]);
      vLJ = mLJ && !(mClr && mSnap[12]);
      vRx = mRx; vChg = mChg;
      if (mClr) begin
        if (mSnap[7]) begin vRx = 0; vChg = mChg && !mSnap[14]; end
        else          begin vChg = 0; vRx = mRx && !mSnap[14]; end
      end
      rl    = mClr && !mSnap[11];
      vLink = rl ? linkRaw : mLink;
      vFell = rl ? 1'b0 : mFell;
      w = '0;
      w[15] = vF; w[14] = mCfg ? vChg : vRx; w[13] = vP; w[12] = vLJ;
      w[11] = vLink; w[10] = partnerPause; w[9] = speed100; w[8] = fullDuplex;
      w[7] = mCfg; w[6] = mMask;
      if (rdStb) mSnap = w;
      mClr  = rdStb;
      mF    = vF | faultStb;
      mP    = vP | pageRxStb;
      mLJ   = vLJ | (speed100 ? lockLossStb : jabberStb);
      mRx   = vRx | rxErrStb;
      mChg  = vChg | (mPrev != linkRaw);
      mFell = vFell | (mPrev && !linkRaw);
      mLink = vLink && linkRaw;
      mPrev = linkRaw;
      if (wrStb) begin mCfg = wrData[7]; mMask = wrData[6]; end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rstN) begin
      bit expIrq;
      expIrq = !mMask && (mCfg ? mChg : (mF | mRx | mP | mLJ | mFell));
      chk({rdData[15], rdData[13]} == {mSnap[15], mSnap[13]}, "R4 sticky 15/13", rdData, mSnap);
      chk(rdData[14] == mSnap[14], "R6 bit14", rdData, mSnap);
      chk(rdData[12] == mSnap[12], "R3 bit12", rdData, mSnap);
      chk(rdData[11] == mSnap[11], "R5 link latch", rdData, mSnap);
      chk(rdData[10:8] == mSnap[10:8] && rdData[5:0] == 0, "R2 live/zero bits", rdData, mSnap);
      chk(rdData[7:6] == mSnap[7:6], "R10 control bits", rdData, mSnap);
      chk(irq == expIrq, mMask ? "R9 irq masked" : (mCfg ? "R8 irq change mode" : "R7 irq event mode"),
          irq, expIrq);
    end
  end

  task automatic rd(output logic [REG_W-1:0] v);
    @(negedge clk) rdStb = 1;
    @(negedge clk) rdStb = 0;
    v = rdData;
  endtask

  task automatic wr(input logic [REG_W-1:0] d);
    @(negedge clk) begin wrStb = 1; wrData = d; end
    @(negedge clk) begin wrStb = 0; wrData = '0; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [REG_W-1:0] v;
    linkRaw = 1; partnerPause = 1; speed100 = 1; fullDuplex = 0;
    idle(3);
    chk(rdData == 0 && irq == 0, "R1 reset state", {rdData, 15'b0, irq}, 0);
    rstN = 1;
    idle(2);
    chk(rdData == 0 && irq == 0, "R1 after reset", {rdData, 15'b0, irq}, 0);

    rd(v); chk(v == 16'h0600, "R2 first read", v, 16'h0600);
    rd(v); chk(v == 16'h0E00, "R5 link follows after read", v, 16'h0E00);

    wr(16'hFFFF);
    rd(v); chk(v == 16'h0EC0, "R10 only bits 7,6 written", v, 16'h0EC0);
    wr(16'h0000);

    // one-cycle link drop, recovered before the read
    @(negedge clk) linkRaw = 0;
    @(negedge clk) linkRaw = 1;
    @(negedge clk);
    chk(irq == 1, "R7 link drop raises irq", irq, 1);
    rd(v); chk(v[11] == 0, "R5 drop held low", v, 0);
    rd(v); chk(v[11] == 1, "R5 released after read", v, 1);
    chk(irq == 0, "R7 irq cleared", irq, 0);

    // event coincident with a read survives
    @(negedge clk) begin rdStb = 1; faultStb = 1; end
    @(negedge clk) begin rdStb = 0; faultStb = 0; end
    chk(rdData[15] == 0, "R4 not in coincident snapshot", rdData[15], 0);
    rd(v); chk(v[15] == 1, "R4 coincident event kept", v[15], 1);
    @(negedge clk);
    chk(irq == 0, "R4 cleared after report", irq, 0);

    // link-change mode
    wr(16'h0080);
    @(negedge clk) rxErrStb = 1;
    @(negedge clk) rxErrStb = 0;
    @(negedge clk);
    chk(irq == 0, "R8 rx error ignored for irq", irq, 0);
    @(negedge clk) linkRaw = 0;
    @(negedge clk) begin chk(irq == 1, "R8 change raises irq", irq, 1); linkRaw = 1; end
    rd(v); chk(v[14] == 1, "R6 bit14 is change flag", v[14], 1);
    @(negedge clk);
    chk(irq == 0, "R8 change cleared", irq, 0);
    wr(16'h0000);
    rd(v); rd(v);

    // mask
    wr(16'h0040);
    @(negedge clk) faultStb = 1;
    @(negedge clk) faultStb = 0;
    @(negedge clk);
    chk(irq == 0, "R9 masked", irq, 0);
    wr(16'h0000);
    chk(irq == 1, "R9 unmask exposes pending", irq, 1);
    rd(v); rd(v);

    // bit 12 source by speed
    speed100 = 0;
    @(negedge clk) lockLossStb = 1;
    @(negedge clk) lockLossStb = 0;
    rd(v); chk(v[12] == 0, "R3 lock loss ignored at 10M", v[12], 0);
    @(negedge clk) jabberStb = 1;
    @(negedge clk) jabberStb = 0;
    rd(v); chk(v[12] == 1, "R3 jabber at 10M", v[12], 1);
    rd(v); chk(v[12] == 0, "R3 cleared after report", v[12], 0);

    // sparse random phase
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      faultStb    = ($urandom % 9) == 0;
      rxErrStb    = ($urandom % 9) == 0;
      pageRxStb   = ($urandom % 9) == 0;
      lockLossStb = ($urandom % 9) == 0;
      jabberStb   = ($urandom % 9) == 0;
      if (($urandom % 13) == 0) linkRaw = ~linkRaw;
      if (($urandom % 40) == 0) speed100 = ~speed100;
      partnerPause = ($urandom % 2) == 1;
      fullDuplex   = ($urandom % 3) == 0;
      rdStb = ($urandom % 4) == 0;
      wrStb = ($urandom % 25) == 0;
      wrData = REG_W'($urandom);
    end
    @(negedge clk);
    {faultStb, rxErrStb, pageRxStb, lockLossStb, jabberStb, rdStb, wrStb} = '0;
    idle(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule